// File: doc/BRIEF.md
# Single-Wire Bus Master Bit Engine

This block times the bus-master side of an open-drain single-wire bus. One command at a time arrives on a small command port: a reset with presence detection, a write of one bit, or a read of one bit. Each command runs at regular or at overdrive speed. The block turns the command into the right low and high intervals on the pad's drive-low enable. It samples the synchronized line level at the moment the slave's answer is sure to be present. When the transaction is over, it pulses `done` for one cycle.

All intervals are counted in clock cycles, derived from the parameter `CLKS_PER_US`, which gives the number of clock cycles in one microsecond (written P below). A transaction never sets the speed for any later transaction: the speed is taken from `cmdOverdrive` when each command is accepted. Byte assembly, ROM-level commands and the pull-up itself sit outside this block.

Top module: `owm_master`

## Requirements
- R1: A reset drives `lineDriveLow` high for 480·P cycles at regular speed and 70·P cycles at overdrive. Driving starts in the cycle after acceptance.
- R2: After a reset releases the line, the block samples the line 70 µs later at regular speed and 8 µs later at overdrive. `presence` becomes 1 if the line was low at that sample and 0 if it was high. The reset then ends 480·P cycles after release, at either speed.
- R3: A write with `cmdBit`=1 and a read each drive the line low for 6·P cycles at regular speed and 1·P cycles at overdrive.
- R4: A write with `cmdBit`=0 drives the line low for 60·P cycles at regular speed and 7·P cycles at overdrive.
- R5: A write or read slot, including its recovery time, lasts 70·P cycles at regular speed and 10·P cycles at overdrive, counted from the first low cycle.
- R6: A read captures the synchronized line level at cycle 15·P−1 of the slot at regular speed and at cycle 2·P−1 at overdrive. `readBit` takes that level, so a slave holding the line low gives 0. `readBit` changes only on reads, and `presence` changes only on resets.
- R7: The block accepts a command only when it is idle and `cmdValid`=1. `cmdOp` encodes the command: 00 is reset, 01 is write of `cmdBit`, 10 is read. `cmdOverdrive`=1 selects overdrive. `busy` is high from the cycle after acceptance until the transaction ends. A command presented while the block is busy is ignored.
- R8: `done` is high for exactly one cycle, in the first cycle after the transaction ends. `busy` is low in that cycle, and the block can accept a command in that same cycle.
- R9: After reset the block is idle: `busy`=0, `done`=0, `lineDriveLow`=0, `presence`=0, `readBit`=1.
- R10: `cmdOp`=11 starts nothing: `busy` and `lineDriveLow` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 2 | Command code (00 reset, 01 write, 10 read, 11 none) |
| cmdBit | input | 1 | Bit value for a write |
| cmdOverdrive | input | 1 | 1 selects overdrive timing |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| presence | output | 1 | Presence seen at the last reset |
| readBit | output | 1 | Bit captured by the last read |
| lineDriveLow | output | 1 | Enable of the pad's low driver |
| lineIn | input | 1 | Line level seen at the pad |

## Verification
A bench slave watches the drive enable and answers on the shared line. After a long low it can give a presence pulse. It can also hold the line low through a read slot. Every one of the eight combinations of command, write bit and speed is run, with the slave answering and with it silent. Low-time and slot-length measurements separate write-0 from write-1 and read, and regular speed from overdrive. The captured presence and read results show that the sample point falls inside the slave's answer and after the master's release. A command poked mid-transaction, and the unused opcode, show that stray input leaves the timing and the idle state untouched.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } owmOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic run;
    logic capPresence;
    logic capRead;
  } owmCtl_t;

  // interval lengths in microseconds
  localparam int US_RST_LOW_REG   = 480;
  localparam int US_RST_LOW_OD    = 70;
  localparam int US_RST_HIGH      = 480;
  localparam int US_PRES_REG      = 70;
  localparam int US_PRES_OD       = 8;
  localparam int US_LOW1_REG      = 6;
  localparam int US_LOW1_OD       = 1;
  localparam int US_LOW0_REG      = 60;
  localparam int US_LOW0_OD       = 7;
  localparam int US_SLOT_REG      = 70;
  localparam int US_SLOT_OD       = 10;
  localparam int US_READ_LIM_REG  = 15;
  localparam int US_READ_LIM_OD   = 2;

endpackage

// File: rtl/owm_datapath.sv
module owm_datapath
  import owm_pkg::*;
#(
  parameter int CLKS_PER_US = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  owmCtl_t          ctl,
  input  logic [1:0]       cmdOp,
  input  logic             cmdBit,
  input  logic             cmdOverdrive,
  input  logic             lineIn,
  output owmOp_e           curOp,
  output logic             hitLowEnd,
  output logic             hitSample,
  output logic             hitEnd,
  output logic             presence,
  output logic             readBit
);

  localparam logic [CNT_W-1:0] C_RST_LOW_REG = CNT_W'(US_RST_LOW_REG * CLKS_PER_US);
  localparam logic [CNT_W-1:0] C_RST_LOW_OD  = CNT_W'(US_RST_LOW_OD * CLKS_PER_US);
  localparam logic [CNT_W-1:0] C_RST_HIGH    = CNT_W'(US_RST_HIGH * CLKS_PER_US);
  localparam logic [CNT_W-1:0] C_PRES_REG    = CNT_W'(US_PRES_REG * CLKS_PER_US);
  localparam logic [CNT_W-1:0] C_PRES_OD     = CNT_W'(US_PRES_OD * CLKS_PER_US);
  localparam logic [CNT_W-1:0] C_LOW1_REG    = CNT_W'(US_LOW1_REG * CLKS_PER_US);
  localparam logic [CNT_W-1:0] C_LOW1_OD     = CNT_W'(US_LOW1_OD * CLKS_PER_US);
  localparam logic [CNT_W-1:0] C_LOW0_REG    = CNT_W'(US_LOW0_REG * CLKS_PER_US);
  localparam logic [CNT_W-1:0] C_LOW0_OD     = CNT_W'(US_LOW0_OD * CLKS_PER_US);
  localparam logic [CNT_W-1:0] C_SLOT_REG    = CNT_W'(US_SLOT_REG * CLKS_PER_US);
  localparam logic [CNT_W-1:0] C_SLOT_OD     = CNT_W'(US_SLOT_OD * CLKS_PER_US);
  localparam logic [CNT_W-1:0] C_RDS_REG     = CNT_W'(US_READ_LIM_REG * CLKS_PER_US - 1);
  localparam logic [CNT_W-1:0] C_RDS_OD      = CNT_W'(US_READ_LIM_OD * CLKS_PER_US - 1);

  owmOp_e           opQ;
  logic             bitQ;
  logic             odQ;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lowEnd;
  logic [CNT_W-1:0] sampleAt;
  logic [CNT_W-1:0] endAt;
  logic             lineSync;

  // command latch and slot timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= OP_NONE;
      bitQ  <= 1'b1;
      odQ   <= 1'b0;
      count <= '0;
    end else if (ctl.start) begin
      opQ   <= owmOp_e'(cmdOp);
      bitQ  <= cmdBit;
      odQ   <= cmdOverdrive;
      count <= '0;
    end else if (ctl.run) begin
      count <= count + CNT_W'(1);
    end
  end

  // interval selection from the latched command
  always_comb begin
    if (opQ == OP_RESET) begin
      lowEnd   = odQ ? C_RST_LOW_OD : C_RST_LOW_REG;
      sampleAt = lowEnd + (odQ ? C_PRES_OD : C_PRES_REG);
      endAt    = lowEnd + C_RST_HIGH;
    end else begin
      if (opQ == OP_WRITE && !bitQ) lowEnd = odQ ? C_LOW0_OD : C_LOW0_REG;
      else                          lowEnd = odQ ? C_LOW1_OD : C_LOW1_REG;
      sampleAt = odQ ? C_RDS_OD : C_RDS_REG;
      endAt    = odQ ? C_SLOT_OD : C_SLOT_REG;
    end
  end

  assign curOp     = opQ;
  assign hitLowEnd = (count == lowEnd - CNT_W'(1));
  assign hitSample = (count == sampleAt);
  assign hitEnd    = (count == endAt - CNT_W'(1));

  // line synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES <= 1) begin : gSync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= lineIn;
      end
      assign lineSync = syncQ;
    end else begin : gSyncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      end
      assign lineSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presence <= 1'b0;
      readBit  <= 1'b1;
    end else begin
      if (ctl.capPresence) presence <= !lineSync;
      if (ctl.capRead)     readBit  <= lineSync;
    end
  end

  // R6: a capture only ever happens while a transaction runs
  a_r6_capture_in_run: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capPresence || ctl.capRead) |-> ctl.run);

endmodule

// File: rtl/owm_control.sv
module owm_control
  import owm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  owmOp_e     curOp,
  input  logic       hitLowEnd,
  input  logic       hitSample,
  input  logic       hitEnd,
  output owmCtl_t    ctl,
  output logic       busy,
  output logic       done,
  output logic       lineDriveLow
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} state_e;

  state_e state;
  state_e stateNext;
  logic   accept;

  assign accept = (state == ST_IDLE) && cmdValid && (owmOp_e'(cmdOp) != OP_NONE);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (accept)    stateNext = ST_LOW;
      ST_LOW:  if (hitLowEnd) stateNext = ST_HIGH;
      ST_HIGH: if (hitEnd)    stateNext = ST_IDLE;
      default:                stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_HIGH) && hitEnd;
    end
  end

  always_comb begin
    ctl.start       = accept;
    ctl.run         = (state != ST_IDLE);
    ctl.capPresence = (state != ST_IDLE) && hitSample && (curOp == OP_RESET);
    ctl.capRead     = (state != ST_IDLE) && hitSample && (curOp == OP_READ);
  end

  assign busy         = (state != ST_IDLE);
  assign lineDriveLow = (state == ST_LOW);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineDriveLow);

  a_r7_start_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> lineDriveLow);

endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int CLKS_PER_US = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdBit,
  input  logic       cmdOverdrive,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       readBit,
  output logic       lineDriveLow,
  input  logic       lineIn
);

  localparam int MAX_CYC = (US_RST_LOW_REG + US_RST_HIGH) * CLKS_PER_US;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  owmCtl_t ctl;
  owmOp_e  curOp;
  logic    hitLowEnd;
  logic    hitSample;
  logic    hitEnd;

  owm_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdOp        (cmdOp),
    .curOp        (curOp),
    .hitLowEnd    (hitLowEnd),
    .hitSample    (hitSample),
    .hitEnd       (hitEnd),
    .ctl          (ctl),
    .busy         (busy),
    .done         (done),
    .lineDriveLow (lineDriveLow)
  );

  owm_datapath #(
    .CLKS_PER_US (CLKS_PER_US),
    .SYNC_STAGES (SYNC_STAGES),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .cmdOp        (cmdOp),
    .cmdBit       (cmdBit),
    .cmdOverdrive (cmdOverdrive),
    .lineIn       (lineIn),
    .curOp        (curOp),
    .hitLowEnd    (hitLowEnd),
    .hitSample    (hitSample),
    .hitEnd       (hitEnd),
    .presence     (presence),
    .readBit      (readBit)
  );

  // R3/R4: release happens exactly where the datapath marks the end of the low phase
  a_r3_release_point: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineDriveLow) |-> $past(hitLowEnd));

  // R5: the done pulse follows the datapath's end-of-transaction mark
  a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(hitEnd));

endmodule

// File: tb/sim_owm_master.sv
module sim_owm_master;

  localparam int CLK_PERIOD = 10;
  localparam int P          = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b11;
  logic       cmdBit = 1'b0;
  logic       cmdOverdrive = 1'b0;
  logic       busy, done, presence, readBit, lineDriveLow;
  logic       slaveLow = 1'b0;
  logic       lineIn;

  int checks = 0;
  int failures = 0;

  // slave behaviour selected per transaction
  bit slvPresent = 0;
  bit slvReadZero = 0;
  bit slvOd = 0;

  assign lineIn = !(lineDriveLow || slaveLow);

  always #(CLK_PERIOD/2) clk = !clk;

  owm_master #(.CLKS_PER_US(P)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBit(cmdBit),
    .cmdOverdrive(cmdOverdrive), .busy(busy), .done(done), .presence(presence),
    .readBit(readBit), .lineDriveLow(lineDriveLow), .lineIn(lineIn)
  );

  // bench slave: answers presence after a long low, holds a read slot low on request
  logic prevLow = 1'b0;
  int   lowRun = 0;
  int   sinceFall = 100000;
  int   sinceRise = 100000;
  bit   afterReset = 0;
  always @(negedge clk) begin
    if (lineDriveLow && !prevLow) begin sinceFall = 0; lowRun = 0; afterReset = 0; end
    if (!lineDriveLow && prevLow) begin afterReset = (lowRun >= 65*P); sinceRise = 0; end
    if (lineDriveLow) lowRun++;
    slaveLow <= (slvReadZero && sinceFall < (slvOd ? 4*P : 30*P)) ||
                (slvPresent && afterReset && !lineDriveLow &&
                 sinceRise >= (slvOd ? 4*P : 30*P) &&
                 sinceRise < (slvOd ? 20*P : 150*P));
    prevLow = lineDriveLow;
    if (sinceFall < 100000) sinceFall++;
    if (sinceRise < 100000) sinceRise++;
  end

  function automatic int expLow(int op, bit b, bit od);
    if (op == 0) return (od ? 70 : 480) * P;
    if (op == 1 && !b) return (od ? 7 : 60) * P;
    return (od ? 1 : 6) * P;
  endfunction

  function automatic int expLen(int op, bit od);
    if (op == 0) return (od ? 70 : 480) * P + 480 * P;
    return (od ? 10 : 70) * P;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  bit expPres = 0;
  bit expRead = 1;

  task automatic runOp(int op, bit b, bit od, bit pres, bit rdZero, bit poke);
    int n;
    int lowCnt;
    string lowReq;
    slvPresent  = pres;
    slvReadZero = (op == 2) && rdZero;
    slvOd       = od;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdBit = b; cmdOverdrive = od;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b11;
    chk(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    n = 1; lowCnt = 0;
    while (!done && n < 20000) begin
      lowCnt += int'(lineDriveLow);
      if (poke && n == 5) begin cmdValid = 1'b1; cmdOp = 2'b00; cmdOverdrive = !od; end
      if (poke && n == 6) begin cmdValid = 1'b0; cmdOp = 2'b11; end
      @(negedge clk);
      n++;
    end
    if (op == 0) lowReq = "R1 reset low";
    else if (op == 1 && !b) lowReq = "R4 write0 low";
    else lowReq = "R3 write1/read low";
    chk(lowCnt == expLow(op, b, od), lowReq, lowCnt, expLow(op, b, od));
    chk(n == expLen(op, od) + 1, op == 0 ? "R2 reset length" : "R5 slot length",
        n, expLen(op, od) + 1);
    chk(busy == 1'b0, "R8 idle in done cycle", int'(busy), 0);
    if (op == 0) expPres = pres;
    if (op == 2) expRead = !rdZero;
    chk(presence == expPres, "R2 presence", int'(presence), int'(expPres));
    chk(readBit == expRead, "R6 readBit", int'(readBit), int'(expRead));
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    if (poke) chk(busy == 1'b0, "R7 busy-time command ignored", int'(busy), 0);
    slvPresent = 0; slvReadZero = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1957);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(busy == 0 && done == 0 && lineDriveLow == 0, "R9 idle outputs",
        int'({busy, done, lineDriveLow}), 0);
    chk(presence == 0, "R9 presence", int'(presence), 0);
    chk(readBit == 1, "R9 readBit", int'(readBit), 1);
    rstN = 1'b1;
    @(negedge clk);

    // directed: every command, both speeds
    runOp(0, 0, 0, 1, 0, 0);   // R1 R2 regular reset with presence
    runOp(0, 0, 1, 0, 0, 0);   // overdrive reset, no slave
    runOp(0, 0, 1, 1, 0, 0);   // overdrive reset with presence
    runOp(1, 1, 0, 0, 0, 0);   // R3 write-1 regular
    runOp(1, 0, 0, 0, 0, 0);   // R4 write-0 regular
    runOp(1, 1, 1, 0, 0, 0);
    runOp(1, 0, 1, 0, 0, 0);
    runOp(2, 0, 0, 0, 1, 0);   // R6 read 0 regular
    runOp(2, 0, 0, 0, 0, 0);   // R6 read 1 regular
    runOp(2, 0, 1, 0, 1, 0);   // R6 read 0 overdrive
    runOp(2, 0, 1, 0, 0, 0);
    runOp(1, 1, 0, 0, 0, 0);   // R6 write leaves readBit
    runOp(2, 0, 1, 0, 1, 1);   // R7 poke while busy
    runOp(0, 0, 0, 0, 0, 1);   // R7 poke during reset

    // R10: unused opcode starts nothing
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'b11;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk(busy == 0 && lineDriveLow == 0, "R10 opcode 11 ignored",
          int'({busy, lineDriveLow}), 0);
      @(negedge clk);
    end

    // constrained random mix
    for (int k = 0; k < 24; k++) begin
      int op;
      int unsigned r;
      r = $urandom;
      op = ((r % 8) == 0) ? 0 : int'(1 + (r >> 3) % 2);
      runOp(op, r[8], r[9], r[10], r[11], r[12] && r[13]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule